// File: doc/BRIEF.md
# Mask-Driven Condition Code Unit

This block produces the 2-bit condition code for two instructions that work through a mask. The first is a test-under-mask. A 16-bit mask picks bits out of the low 16 bits of an operand, and the code reports whether the picked bits are all clear, all set, or mixed. The narrow variant reports every mixed result the same way. The wide variant splits mixed results by the operand bit that sits under the most significant set mask bit. The second instruction is an insert-bytes-under-mask. A 4-bit lane mask states how many bytes were loaded, and the result word holds those bytes packed against the right edge. The code then gives the sign of the leftmost inserted byte, or zero.

The mode, the operand and the mask are applied together. The code appears on the output after the next rising clock edge. The leftmost set mask bit and the leftmost inserted byte are each found in a single pass of logic, so one new operation can be accepted on every clock. The byte insertion itself is done elsewhere. This unit only grades the outcome.

Top module: `mtcc_mask_cc`

## Requirements
- R1: While rst_n is low, cc is 0. The first code after reset is released is computed from the inputs present at that edge.
- R2: cc is registered. On each rising edge with rst_n high, cc takes the code for the mode, value and mask present at that edge, so a new operation can be applied every cycle.
- R3: In mode 0 (narrow test) and mode 1 (wide test), the selected bits are value[15:0] & mask. cc is 0 when the mask is zero or when the selected bits are all zero.
- R4: In modes 0 and 1, cc is 3 when the mask is nonzero and every selected bit is one.
- R5: In mode 0, any mixed result gives cc = 1. A mixed result has some selected bits that are one and some that are zero.
- R6: In mode 1, a mixed result gives cc = 2 when value bit p is one and cc = 1 when it is zero. Here p is the index of the most significant set bit of the mask.
- R7: In modes 0 and 1, value[63:16] has no effect on cc.
- R8: In mode 2 (insert) with mask[3:0] = 4'hF, cc is 0 for value[31:0] = 0, 1 when value[31] is set, and 2 otherwise.
- R9: In mode 2 with any mask[3:0], cc is 0 when mask[3:0] is zero or value[31:0] is zero. Otherwise let n be the number of set bits in mask[3:0]. cc is 1 when value bit 8n-1 is set and 2 when it is clear.
- R10: In mode 2, mask[15:4] and value[63:32] have no effect, and cc is never 3.
- R11: Mode 3 is reserved and gives cc = 0 for any value and mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 narrow test, 1 wide test, 2 insert, 3 reserved |
| value | input | 64 | Operand for the tests, or the packed inserted word in its low 32 bits |
| mask | input | 16 | Test mask; in insert mode only bits 3:0 are used as lane mask |
| cc | output | 2 | Registered condition code |

## Verification
The bench targets the wide-test mixed case with the mask's leading bit placed far from the operand's set bits, and with a sparse mask whose leading bit sits over a zero. A design that tested the wrong bit, or that treated every mixed result as narrow, would return 1 where 2 is due. For insertion it uses sparse lane masks such as 4'b1000 and 4'b0101. A design that took the sign from the byte lane's position rather than from the packed count would read the wrong byte and flip between 1 and 2. Upper operand bits and upper mask bits are filled with ones while the relevant fields stay zero, which exposes any leak into the all-zero case. Alternating outcomes on consecutive cycles expose a stale or skewed output register.

// File: rtl/mtcc_pkg.sv
package mtcc_pkg;

  typedef enum logic [1:0] {
    MT_TM_NARROW = 2'd0,
    MT_TM_WIDE   = 2'd1,
    MT_INSERT    = 2'd2,
    MT_RESERVED  = 2'd3
  } mt_mode_e;

  typedef logic [1:0] cc_t;

  localparam cc_t CC_ZERO  = 2'd0;
  localparam cc_t CC_LOW   = 2'd1;
  localparam cc_t CC_HIGH  = 2'd2;
  localparam cc_t CC_ALL   = 2'd3;

  // Grade of a test-under-mask result from its three events.
  function automatic cc_t tm_grade(input logic sel_zero, input logic sel_full,
                                   input logic wide, input logic lead_bit);
    if (sel_zero)      return CC_ZERO;
    else if (sel_full) return CC_ALL;
    else if (wide)     return lead_bit ? CC_HIGH : CC_LOW;
    else               return CC_LOW;
  endfunction

  // Grade of an insert result: empty gives zero, otherwise sign of lead byte.
  function automatic cc_t ins_grade(input logic empty, input logic lead_sign);
    if (empty) return CC_ZERO;
    return lead_sign ? CC_LOW : CC_HIGH;
  endfunction

endpackage

// File: rtl/mtcc_lead_enc.sv
module mtcc_lead_enc #(
  parameter int W     = 16,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  logic [W-1:0] clear_above;
  logic [W-1:0] hit;

  assign clear_above[W-1] = 1'b1;
  genvar g;
  generate
    for (g = W - 2; g >= 0; g--) begin : g_chain
      assign clear_above[g] = clear_above[g+1] & ~vec[g+1];
    end
    for (g = 0; g < W; g++) begin : g_hit
      assign hit[g] = vec[g] & clear_above[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (hit[i]) idx = idx | IDX_W'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/mtcc_tm_unit.sv
module mtcc_tm_unit
  import mtcc_pkg::*;
#(
  parameter int FIELD_W = 16
) (
  input  logic [FIELD_W-1:0] field,
  input  logic [FIELD_W-1:0] mask,
  input  logic               wide,
  output cc_t                code,
  output logic               sel_zero,
  output logic               sel_full,
  output logic               lead_bit
);
  localparam int IDX_W = (FIELD_W > 1) ? $clog2(FIELD_W) : 1;

  logic [FIELD_W-1:0] sel;
  logic [IDX_W-1:0]   lead_idx;
  logic               mask_any;

  assign sel = field & mask;

  mtcc_lead_enc #(.W(FIELD_W)) u_lead (
    .vec (mask),
    .idx (lead_idx),
    .any (mask_any)
  );

  assign sel_zero = ~|sel;
  assign sel_full = mask_any && (sel == mask);
  assign lead_bit = field[lead_idx];
  assign code     = tm_grade(sel_zero, sel_full, wide, lead_bit);
endmodule

// File: rtl/mtcc_ins_unit.sv
module mtcc_ins_unit
  import mtcc_pkg::*;
#(
  parameter int LANES  = 4,
  localparam int WORD_W = 8 * LANES,
  localparam int CNT_W  = $clog2(LANES + 1),
  localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [WORD_W-1:0] word,
  input  logic [LANES-1:0]  lanes,
  output cc_t               code,
  output logic [CNT_W-1:0]  lane_cnt,
  output logic              lead_sign
);
  function automatic logic [CNT_W-1:0] count_set(input logic [LANES-1:0] m);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < LANES; i++) s = s + CNT_W'(m[i]);
    return s;
  endfunction

  logic [LANES-1:0] sign_cand;
  logic [IDX_W-1:0] lead_idx;
  logic             empty;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_sign
      assign sign_cand[g] = word[8*g+7];
    end
  endgenerate

  assign lane_cnt  = count_set(lanes);
  assign lead_idx  = IDX_W'(lane_cnt - CNT_W'(1));
  assign empty     = (lane_cnt == '0) || (word == '0);
  assign lead_sign = (lane_cnt != '0) && sign_cand[lead_idx];
  assign code      = ins_grade(empty, lead_sign);
endmodule

// File: rtl/mtcc_mask_cc.sv
module mtcc_mask_cc
  import mtcc_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int FIELD_W = 16,
  parameter int LANES   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic [DATA_W-1:0]  value,
  input  logic [FIELD_W-1:0] mask,
  output logic [1:0]         cc
);
  localparam int WORD_W = 8 * LANES;
  localparam int CNT_W  = $clog2(LANES + 1);

  cc_t              tm_code;
  cc_t              ins_code;
  cc_t              cc_next;
  logic             tm_sel_zero;
  logic             tm_sel_full;
  logic             tm_lead_bit;
  logic [CNT_W-1:0] ins_lane_cnt;
  logic             ins_lead_sign;
  mt_mode_e         mode_e;

  assign mode_e = mt_mode_e'(mode);

  mtcc_tm_unit #(.FIELD_W(FIELD_W)) u_tm (
    .field    (value[FIELD_W-1:0]),
    .mask     (mask),
    .wide     (mode_e == MT_TM_WIDE),
    .code     (tm_code),
    .sel_zero (tm_sel_zero),
    .sel_full (tm_sel_full),
    .lead_bit (tm_lead_bit)
  );

  mtcc_ins_unit #(.LANES(LANES)) u_ins (
    .word      (value[WORD_W-1:0]),
    .lanes     (mask[LANES-1:0]),
    .code      (ins_code),
    .lane_cnt  (ins_lane_cnt),
    .lead_sign (ins_lead_sign)
  );

  always_comb begin
    unique case (mode_e)
      MT_TM_NARROW, MT_TM_WIDE: cc_next = tm_code;
      MT_INSERT:                cc_next = ins_code;
      default:                  cc_next = CC_ZERO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc <= CC_ZERO;
    else        cc <= cc_next;
  end
endmodule

// File: rtl/mtcc_mask_cc_chk.sv
module mtcc_mask_cc_chk #(
  parameter int DATA_W  = 64,
  parameter int FIELD_W = 16,
  parameter int LANES   = 4,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode,
  input logic [DATA_W-1:0]  value,
  input logic [FIELD_W-1:0] mask,
  input logic [1:0]         cc,
  input logic               tm_sel_zero,
  input logic               tm_sel_full,
  input logic               tm_lead_bit,
  input logic [CNT_W-1:0]   ins_lane_cnt,
  input logic               ins_lead_sign
);
  logic is_test, ins_empty;
  assign is_test   = (mode == 2'd0) || (mode == 2'd1);
  assign ins_empty = (mask[LANES-1:0] == '0) || (value[8*LANES-1:0] == '0);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> cc == 2'd0); // R1
  AST_TM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(is_test) && $past(tm_sel_zero) |-> cc == 2'd0); // R3
  AST_TM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(is_test) && $past(tm_sel_full) |-> cc == 2'd3); // R4
  AST_TM_NARROW_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(mode == 2'd0) && !$past(tm_sel_zero) && !$past(tm_sel_full)
    |-> cc == 2'd1); // R5
  AST_TM_WIDE_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(mode == 2'd1) && !$past(tm_sel_zero) && !$past(tm_sel_full)
    |-> cc == ($past(tm_lead_bit) ? 2'd2 : 2'd1)); // R6
  AST_INS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(mode == 2'd2) && $past(ins_empty) |-> cc == 2'd0); // R9
  AST_INS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(mode == 2'd2) && !$past(ins_empty) && $past(ins_lane_cnt != '0)
    |-> cc == ($past(ins_lead_sign) ? 2'd1 : 2'd2)); // R8
  AST_INS_NEVER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(mode == 2'd2) |-> cc != 2'd3); // R10
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(mode == 2'd3) |-> cc == 2'd0); // R11
endmodule

bind mtcc_mask_cc mtcc_mask_cc_chk #(
  .DATA_W(DATA_W), .FIELD_W(FIELD_W), .LANES(LANES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode          (mode),
  .value         (value),
  .mask          (mask),
  .cc            (cc),
  .tm_sel_zero   (tm_sel_zero),
  .tm_sel_full   (tm_sel_full),
  .tm_lead_bit   (tm_lead_bit),
  .ins_lane_cnt  (ins_lane_cnt),
  .ins_lead_sign (ins_lead_sign)
);

// File: tb/mtcc_mask_cc_bench.sv
`timescale 1ns/1ps
module mtcc_mask_cc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode;
  logic [63:0] value;
  logic [15:0] mask;
  logic [1:0]  cc;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    pend = 0;
  bit    done = 0;
  logic [1:0]  pend_exp;
  string pend_tag;

  always #2.5 clk = ~clk;

  mtcc_mask_cc u_mtcc_mask_cc (
    .clk(clk), .rst_n(rst_n), .mode(mode), .value(value), .mask(mask), .cc(cc)
  );

  function automatic void ref_model(input logic [1:0] m, input logic [63:0] v,
                                    input logic [15:0] k, output logic [1:0] c,
                                    output string t);
    int lanes_set;
    int lead;
    logic [31:0] w;
    logic [15:0] picked;
    c = 2'd0;
    if (m == 2'd3) begin
      t = "R11";
    end else if (m == 2'd2) begin
      w = v[31:0];
      lanes_set = 0;
      for (int i = 0; i < 4; i++) if (k[i]) lanes_set++;
      if (lanes_set == 0 || w == 0) begin
        c = 2'd0; t = "R9";
      end else begin
        c = w[8*lanes_set-1] ? 2'd1 : 2'd2;
        t = (lanes_set == 4) ? "R8" : "R9";
      end
    end else begin
      picked = v[15:0] & k;
      if (k == 0 || picked == 0) begin
        c = 2'd0; t = "R3";
      end else if (picked == k) begin
        c = 2'd3; t = "R4";
      end else if (m == 2'd0) begin
        c = 2'd1; t = "R5";
      end else begin
        lead = -1;
        for (int i = 15; i >= 0; i--) if (lead < 0 && k[i]) lead = i;
        c = v[lead] ? 2'd2 : 2'd1; t = "R6";
      end
    end
  endfunction

  task automatic check(input logic [1:0] exp, input string tag);
    n_vec++;
    if (cc !== exp) begin
      n_bad++;
      $display("FAIL %s: cc=%0d expected %0d", tag, cc, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [63:0] v,
                       input logic [15:0] k, input string tag);
    logic [1:0] c;
    string t;
    @(negedge clk);
    if (pend) check(pend_exp, pend_tag);
    mode = m; value = v; mask = k;
    ref_model(m, v, k, c, t);
    pend_exp = c;
    pend_tag = (tag != "") ? tag : t;
    pend = 1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: run still active, expected completion");
    summary();
  end

  initial begin
    mode = 2'd1; value = 64'hFFFF; mask = 16'hFFFF;
    repeat (3) begin
      @(negedge clk);
      check(2'd0, "R1");
    end
    @(negedge clk);
    mode = 2'd3; value = '0; mask = '0;
    rst_n = 1'b1;
    pend_exp = 2'd0; pend_tag = "R1"; pend = 1;

    // R3 empty selections
    apply(2'd0, 64'hFFFF, 16'h0000, "R3");
    apply(2'd1, 64'hFF0F, 16'h00F0, "R3");
    // R4 all selected ones
    apply(2'd0, 64'h8001, 16'h8001, "R4");
    apply(2'd1, 64'hFFFF, 16'hFFFF, "R4");
    // R5 narrow mixed
    apply(2'd0, 64'h0080, 16'h00FF, "R5");
    apply(2'd0, 64'h8001, 16'hFF00, "R5");
    // R6 wide mixed, leading mask bit over one then over zero
    apply(2'd1, 64'h0800, 16'h0F00, "R6");
    apply(2'd1, 64'h0100, 16'h0F00, "R6");
    apply(2'd1, 64'h4000, 16'h4001, "R6");
    apply(2'd1, 64'h0001, 16'h4001, "R6");
    // R7 upper operand bits ignored
    apply(2'd0, 64'hFFFF_FFFF_FFFF_0000, 16'h00FF, "R7");
    apply(2'd1, 64'hFFFF_FFFF_FFFF_0000, 16'hFFFF, "R7");
    apply(2'd1, 64'hFFFF_FFFF_FFFF_8000, 16'h8001, "R7");
    // R8 full lane mask
    apply(2'd2, 64'h0, 16'h000F, "R8");
    apply(2'd2, 64'h8000_0000, 16'h000F, "R8");
    apply(2'd2, 64'h7FFF_FFFF, 16'h000F, "R8");
    apply(2'd2, 64'h0000_0080, 16'h000F, "R8");
    // R9 partial lane masks, packed count picks the byte
    apply(2'd2, 64'h1234_5680, 16'h0000, "R9");
    apply(2'd2, 64'h0000_0080, 16'h0001, "R9");
    apply(2'd2, 64'h0000_007F, 16'h0008, "R9");
    apply(2'd2, 64'h0000_0080, 16'h0008, "R9");
    apply(2'd2, 64'h0000_8000, 16'h0005, "R9");
    apply(2'd2, 64'h0000_0080, 16'h0005, "R9");
    apply(2'd2, 64'h0080_0000, 16'h0007, "R9");
    apply(2'd2, 64'h0040_0000, 16'h0007, "R9");
    // R10 upper mask and upper word ignored
    apply(2'd2, 64'hFFFF_FFFF, 16'hFFF0, "R10");
    apply(2'd2, 64'hFFFF_FFFF_0000_0001, 16'hFF01, "R10");
    apply(2'd2, 64'hFFFF_FFFF_0000_0000, 16'h000F, "R10");
    // R11 reserved mode
    apply(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, "R11");
    apply(2'd3, 64'h8000_0000, 16'h000F, "R11");
    // R2 back-to-back alternating outcomes
    apply(2'd1, 64'hFFFF, 16'hFFFF, "R2");
    apply(2'd0, 64'h0000, 16'hFFFF, "R2");
    apply(2'd2, 64'h8000_0000, 16'h000F, "R2");
    apply(2'd1, 64'hFFFF, 16'hFFFF, "R2");

    for (int n = 0; n < 3000; n++) begin
      logic [63:0] v;
      logic [15:0] k;
      logic [1:0]  m;
      m = 2'($urandom % 4);
      v = {$urandom, $urandom};
      k = 16'($urandom);
      case ($urandom % 4)
        0: k = k & 16'($urandom);
        1: v[15:0] = v[15:0] | k;
        2: v[31:0] = v[31:0] & {$urandom, $urandom} & 32'($urandom);
        default: ;
      endcase
      apply(m, v, k, "");
    end

    @(negedge clk);
    if (pend) check(pend_exp, pend_tag);
    pend = 0;
    summary();
  end
endmodule